// File: doc/BRIEF.md
# Increment-and-Skip Execution Slice

This block executes two single-word opcodes of a small 8-bit accumulator-style core. Both add one to a data-memory byte; one of them then skips the following instruction when the new value is zero, the other skips it when the new value is non-zero. The unit decodes the 16-bit instruction word. It builds a 12-bit data address from an 8-bit register field, a 4-bit bank register and an access-bank bit. It reads the byte over a register-file port, increments it, and sends the sum either to the working register W or back to the same address.

Each instruction occupies one instruction cycle of four clocks. The phases are decode, read, process and write. The decode phase is the clock on which the word is accepted. When the skip condition holds, the unit pulses `flush` so that fetch logic discards the prefetched instruction. It then spends one further instruction cycle in no-operation phases, or two cycles if that prefetched instruction was two words long, with `nop_busy` high throughout. No arithmetic status flags are produced.

Instruction words arrive on a valid/ready stream. A word is taken on a clock edge where `insn_valid` and `insn_ready` are both high. While `insn_valid` is high and `insn_ready` is low, the source must hold `insn_word` unchanged. `bank_sel` and `insn_next_two_word` are plain control pins, sampled only on the accepting edge.

Top module: `incskip_unit`

## Requirements
- R1: `insn_ready` is high only while the unit waits in the decode phase. A word is accepted on an edge where `insn_valid` and `insn_ready` are both high, and `insn_ready` is low on the clock after acceptance. A word held valid while `insn_ready` is low is accepted on the first clock where `insn_ready` returns high.
- R2: Decoding works as follows. Bits [15:10] = 6'b001111 select increment-skip-if-zero, and bits [15:10] = 6'b010010 select increment-skip-if-nonzero. Bit 9 is the destination bit d, bit 8 is the access bit a, and bits [7:0] are the register field f. Any other word is consumed in four clocks with no read, no write, no change of W and no flush.
- R3: With a = 1 the data address is {bank_sel, f}. With a = 0, an f below 8'h80 maps to {4'h0, f} and an f of 8'h80 or above maps to {4'hF, f}. `rf_re` is high with that address on the second clock of the instruction, and `rf_rdata` is taken on the clock after.
- R4: With d = 1, `rf_we` is high on the fourth clock of the instruction. `rf_waddr` then carries the read address and `rf_wdata` carries (operand + 1) mod 256. W does not change.
- R5: With d = 0, W takes (operand + 1) mod 256 at the end of the fourth clock, and `rf_we` stays low.
- R6: The zero variant skips exactly when the 8-bit sum is zero, which includes the wrap from 8'hFF. The non-zero variant skips exactly when the sum is not zero.
- R7: `flush` is a single-clock pulse on the fourth clock of an instruction that skips, and it is low on every other clock.
- R8: After a skip, `nop_busy` is high for 4 clocks, or for 8 clocks when `insn_next_two_word` was 1 at acceptance. `insn_ready` stays low during those clocks. Without a skip, `insn_ready` returns on the clock after the fourth.
- R9: While reset is asserted, `insn_ready` is 1, and `rf_re`, `rf_we`, `flush`, `nop_busy` and W are 0.
- R10: `bank_sel` and `insn_next_two_word` are sampled on the accepting edge only. Later changes to them do not alter that instruction's address or no-op length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit can take a word this clock |
| insn_word | input | 16 | Instruction word |
| insn_next_two_word | input | 1 | Prefetched next instruction is two words long |
| bank_sel | input | BANK_W | Bank register value |
| rf_re | output | 1 | Register-file read request |
| rf_raddr | output | BANK_W+8 | Read address |
| rf_rdata | input | DATA_W | Read data, one clock after `rf_re` |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | BANK_W+8 | Write address |
| rf_wdata | output | DATA_W | Write data |
| w_out | output | DATA_W | Working register W |
| flush | output | 1 | Discard the prefetched instruction |
| nop_busy | output | 1 | Inserted no-op cycles in progress |

## Verification
The main function is exercised with operands that sit away from the wrap point and operands equal to 8'hFF. For both opcode variants, these two cases separate a skip from a non-skip. Each is run with both destinations, so a write to memory can be told apart from a load of W. Addresses on both sides of the 8'h80 split under a = 0, and under a = 1 with several bank values, show that the bank register is obeyed or ignored as specified. Several other patterns are also applied:
- back-to-back words held valid across busy clocks;
- repeated increments of a single address;
- unrecognised opcodes;
- control pins that change after acceptance.

Together these patterns cover the hand-shake, read-after-write and sampling rules.

// File: rtl/incskip_pkg.sv
package incskip_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [2:0] {
    PH_DECODE  = 3'd0,
    PH_READ    = 3'd1,
    PH_PROCESS = 3'd2,
    PH_WRITE   = 3'd3,
    PH_NOP     = 3'd4
  } phase_e;

  localparam logic [5:0] OPC_INC_SKZ  = 6'b001111;
  localparam logic [5:0] OPC_INC_SKNZ = 6'b010010;
  localparam int         FIELD_W      = 8;

  typedef struct packed {
    logic hit;          // recognised opcode
    logic skip_on_zero; // 1: skip when sum is zero, 0: skip when non-zero
    logic to_file;      // destination bit
  } op_ctl_t;
endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
  import incskip_pkg::*;
#(
  parameter int BANK_W = 4,
  localparam int ADDR_W = BANK_W + FIELD_W
) (
  input  logic [15:0]       word,
  input  logic [BANK_W-1:0] bank,
  output op_ctl_t           ctl,
  output logic [ADDR_W-1:0] addr
);
  timeunit 1ns; timeprecision 100ps;

  logic [5:0]         opc;
  logic               acc_n;
  logic [FIELD_W-1:0] reg_f;
  logic [BANK_W-1:0]  low_bank;

  assign opc   = word[15:10];
  assign acc_n = word[8];
  assign reg_f = word[FIELD_W-1:0];

  // Access bank: lower half of the field selects bank zero, upper half the top bank.
  assign low_bank = reg_f[FIELD_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};

  always_comb begin
    ctl.hit          = (opc == OPC_INC_SKZ) || (opc == OPC_INC_SKNZ);
    ctl.skip_on_zero = (opc == OPC_INC_SKZ);
    ctl.to_file      = word[9];
    addr             = acc_n ? {bank, reg_f} : {low_bank, reg_f};
  end
endmodule

// File: rtl/incskip_seq.sv
module incskip_seq
  import incskip_pkg::*;
#(
  parameter int PHASES = 4,
  localparam int CNT_W = $clog2(2 * PHASES)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   two_word,
  input  logic   skip_now,
  output phase_e phase,
  output logic   accept,
  output logic   ready,
  output logic   nop_busy
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [CNT_W-1:0] LOAD_ONE = CNT_W'(PHASES - 1);
  localparam logic [CNT_W-1:0] LOAD_TWO = CNT_W'(2 * PHASES - 1);

  phase_e           phase_q, phase_d;
  logic             two_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign phase    = phase_q;
  assign ready    = (phase_q == PH_DECODE);
  assign accept   = ready && in_valid;
  assign nop_busy = (phase_q == PH_NOP);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_DECODE:  if (accept) phase_d = PH_READ;
      PH_READ:    phase_d = PH_PROCESS;
      PH_PROCESS: phase_d = PH_WRITE;
      PH_WRITE: begin
        if (skip_now) begin
          phase_d = PH_NOP;
          cnt_d   = two_q ? LOAD_TWO : LOAD_ONE;
        end else begin
          phase_d = PH_DECODE;
        end
      end
      PH_NOP: begin
        if (cnt_q == '0) phase_d = PH_DECODE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_DECODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_DECODE;
      cnt_q   <= '0;
      two_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (accept) two_q <= two_word;
    end
  end
endmodule

// File: rtl/incskip_datapath.sv
module incskip_datapath
  import incskip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  op_ctl_t           in_ctl,
  input  logic [ADDR_W-1:0] in_addr,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] w_q,
  output logic              skip_now
);
  timeunit 1ns; timeprecision 100ps;

  op_ctl_t           ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] sum;
  logic              sum_zero;
  logic              in_write;

  assign sum      = opnd_q + 1'b1;
  assign sum_zero = (sum == '0);
  assign in_write = (phase == PH_WRITE) && ctl_q.hit;

  assign addr     = addr_q;
  assign rd_en    = (phase == PH_READ) && ctl_q.hit;
  assign wr_en    = in_write && ctl_q.to_file;
  assign wr_data  = sum;
  assign skip_now = in_write && (ctl_q.skip_on_zero ? sum_zero : !sum_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      w_q    <= '0;
    end else begin
      if (accept) begin
        ctl_q  <= in_ctl;
        addr_q <= in_addr;
      end
      if (phase == PH_PROCESS) opnd_q <= rd_data;
      if (in_write && !ctl_q.to_file) w_q <= sum;
    end
  end
endmodule

// File: rtl/incskip_unit.sv
module incskip_unit
  import incskip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insn_valid,
  output logic                  insn_ready,
  input  logic [15:0]           insn_word,
  input  logic                  insn_next_two_word,
  input  logic [BANK_W-1:0]     bank_sel,
  output logic                  rf_re,
  output logic [BANK_W+7:0]     rf_raddr,
  input  logic [DATA_W-1:0]     rf_rdata,
  output logic                  rf_we,
  output logic [BANK_W+7:0]     rf_waddr,
  output logic [DATA_W-1:0]     rf_wdata,
  output logic [DATA_W-1:0]     w_out,
  output logic                  flush,
  output logic                  nop_busy
);
  timeunit 1ns; timeprecision 100ps;

  localparam int ADDR_W = BANK_W + FIELD_W;

  op_ctl_t           dec_ctl;
  logic [ADDR_W-1:0] dec_addr;
  logic [ADDR_W-1:0] cur_addr;
  phase_e            phase;
  logic              accept;
  logic              skip_now;

  incskip_decode #(.BANK_W(BANK_W)) u_decode (
    .word (insn_word),
    .bank (bank_sel),
    .ctl  (dec_ctl),
    .addr (dec_addr)
  );

  incskip_seq #(.PHASES(PHASES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (insn_valid),
    .two_word (insn_next_two_word),
    .skip_now (skip_now),
    .phase    (phase),
    .accept   (accept),
    .ready    (insn_ready),
    .nop_busy (nop_busy)
  );

  incskip_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .in_ctl   (dec_ctl),
    .in_addr  (dec_addr),
    .phase    (phase),
    .rd_data  (rf_rdata),
    .rd_en    (rf_re),
    .addr     (cur_addr),
    .wr_en    (rf_we),
    .wr_data  (rf_wdata),
    .w_q      (w_out),
    .skip_now (skip_now)
  );

  assign rf_raddr = cur_addr;
  assign rf_waddr = cur_addr;
  assign flush    = skip_now;
endmodule

// File: rtl/incskip_unit_chk.sv
module incskip_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_valid,
  input logic              insn_ready,
  input logic              rf_re,
  input logic              rf_we,
  input logic              flush,
  input logic              nop_busy,
  input logic [DATA_W-1:0] w_out
);
  timeunit 1ns; timeprecision 100ps;

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_ready) |=> !insn_ready);

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    insn_ready |-> (!rf_re && !rf_we && !nop_busy));

  assert_read_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re);

  assert_file_write_keeps_w_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> $stable(w_out));

  assert_w_only_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(w_out) |-> $past(!rf_we && !insn_ready));

  assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  assert_flush_not_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !insn_ready && !nop_busy);

  assert_nop_follows_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> nop_busy);

  assert_nop_blocks_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nop_busy |-> !insn_ready);
endmodule

bind incskip_unit incskip_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn_ready (insn_ready),
  .rf_re      (rf_re),
  .rf_we      (rf_we),
  .flush      (flush),
  .nop_busy   (nop_busy),
  .w_out      (w_out)
);

// File: tb/test_incskip_unit.sv
module test_incskip_unit;
  timeunit 1ns; timeprecision 100ps;

  typedef struct {
    bit re; int raddr; bit we; int waddr; int wdata;
    bit flush; bit nopb; int w; bit rdy;
  } exp_t;

  typedef struct {
    logic [15:0] word; bit two; logic [3:0] bsr; int gap;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [15:0] insn_word = '0;
  logic        insn_next_two_word = 1'b0;
  logic [3:0]  bank_sel = '0;
  logic        rf_re, rf_we, flush, nop_busy;
  logic [11:0] rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata = '0;
  logic [7:0]  rf_wdata, w_out;

  logic [7:0] rf_mem  [4096];
  int         ref_mem [4096];
  int         model_w = 0;
  exp_t       expq[$];
  item_t      pend[$];
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  incskip_unit i_incskip_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .insn_next_two_word(insn_next_two_word), .bank_sel(bank_sel),
    .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .w_out(w_out), .flush(flush),
    .nop_busy(nop_busy)
  );

  // register file environment: one-clock read latency
  always @(posedge clk) begin
    if (rf_re) rf_rdata <= rf_mem[rf_raddr];
    if (rf_we) rf_mem[rf_waddr] <= rf_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // behavioural model: runs at acceptance, queues per-clock expectations
  task automatic model_accept(input item_t it);
    int op, d, a, f, addr, res, hit, skip, n;
    exp_t e;
    op = int'(it.word[15:10]); d = int'(it.word[9]); a = int'(it.word[8]); f = int'(it.word[7:0]);
    hit  = (op == 'h0F || op == 'h12) ? 1 : 0;
    addr = (a == 1) ? int'(it.bsr) * 256 + f : ((f >= 128) ? 15 * 256 + f : f);
    res  = (ref_mem[addr] + 1) % 256;
    skip = hit && ((op == 'h0F) ? (res == 0) : (res != 0));
    e = '{re:0, raddr:0, we:0, waddr:0, wdata:0, flush:0, nopb:0, w:model_w, rdy:0};
    e.re = hit[0]; e.raddr = addr;                   expq.push_back(e); // phase 2
    e.re = 0;                                        expq.push_back(e); // phase 3
    e.we = hit[0] && d[0]; e.waddr = addr; e.wdata = res; e.flush = skip[0];
    expq.push_back(e);                                                   // phase 4
    if (hit && d == 1) ref_mem[addr] = res;
    if (hit && d == 0) model_w = res;
    n = skip ? (it.two ? 8 : 4) : 0;
    e = '{re:0, raddr:0, we:0, waddr:0, wdata:0, flush:0, nopb:1, w:model_w, rdy:0};
    for (int k = 0; k < n; k++) expq.push_back(e);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !done) begin
      if (expq.size() > 0) e = expq.pop_front();
      else e = '{re:0, raddr:0, we:0, waddr:0, wdata:0, flush:0, nopb:0, w:model_w, rdy:1};
      chk(insn_ready == e.rdy, "R1 insn_ready", int'(insn_ready), int'(e.rdy));
      chk(rf_re == e.re, "R2/R3 rf_re", int'(rf_re), int'(e.re));
      if (e.re) chk(int'(rf_raddr) == e.raddr, "R3 R10 rf_raddr", int'(rf_raddr), e.raddr);
      chk(rf_we == e.we, "R2/R4 rf_we", int'(rf_we), int'(e.we));
      if (e.we) begin
        chk(int'(rf_waddr) == e.waddr, "R4 rf_waddr", int'(rf_waddr), e.waddr);
        chk(int'(rf_wdata) == e.wdata, "R4 rf_wdata", int'(rf_wdata), e.wdata);
      end
      chk(flush == e.flush, "R6 R7 flush", int'(flush), int'(e.flush));
      chk(nop_busy == e.nopb, "R8 R10 nop_busy", int'(nop_busy), int'(e.nopb));
      chk(int'(w_out) == e.w, "R5 w_out", int'(w_out), e.w);
    end
  end

  function automatic logic [15:0] mk(input bit nz, input bit d, input bit a, input int f);
    mk = {nz ? 6'b010010 : 6'b001111, d, a, 8'(f)};
  endfunction

  task automatic add(input logic [15:0] w, input bit two, input int bsr, input int gap);
    item_t it;
    it.word = w; it.two = two; it.bsr = 4'(bsr); it.gap = gap;
    pend.push_back(it);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      rf_mem[i] = 8'((i * 37 + 11) & 255);
    end
    rf_mem['h220] = 8'hFF; rf_mem['h221] = 8'hFF; rf_mem['h030] = 8'hFF;
    rf_mem['hFA0] = 8'hFF; rf_mem['h540] = 8'hFE;
    for (int i = 0; i < 4096; i++) ref_mem[i] = int'(rf_mem[i]);

    // directed patterns
    add(mk(0, 1, 1, 'h10), 0, 2, 1);   // R6 zero variant, no skip, to file
    add(mk(0, 1, 1, 'h20), 0, 2, 2);   // R6 wrap skip, one no-op cycle (R8)
    add(mk(0, 1, 1, 'h21), 1, 2, 0);   // R8 wrap skip, two-word next
    add(mk(1, 0, 0, 'h05), 0, 9, 1);   // R5 R3 access bank low, non-zero skip
    add(mk(1, 0, 0, 'h30), 1, 9, 0);   // R6 non-zero variant on 0xFF: no skip
    add(mk(1, 1, 0, 'hA0), 1, 3, 1);   // R3 access bank high half, wraps, no skip
    add(mk(0, 0, 0, 'hA0), 1, 3, 0);   // R3 same byte now 0x00 -> sum 1
    add(16'h1234, 1, 0, 1);            // R2 unknown opcode
    add(16'hFFFF, 0, 0, 0);            // R2 unknown opcode, back-to-back
    add(mk(0, 1, 1, 'h40), 0, 5, 0);   // R4 0xFE -> 0xFF, read-after-write next
    add(mk(0, 1, 1, 'h40), 1, 5, 0);   // R6 0xFF -> 0x00, skip
    for (int i = 0; i < 40; i++)       // varied patterns
      add(mk(i[0], i[1], i[2], (i * 53 + 7) & 255), i[3], (i * 5) & 15, i % 3);

    repeat (4) @(negedge clk);
    // R9 reset state
    chk(insn_ready === 1'b1, "R9 ready in reset", int'(insn_ready), 1);
    chk(!rf_re && !rf_we, "R9 strobes in reset", int'({rf_re, rf_we}), 0);
    chk(!flush && !nop_busy, "R9 flush/nop in reset", int'({flush, nop_busy}), 0);
    chk(w_out === 8'h00, "R9 W in reset", int'(w_out), 0);
    #1 rst_n = 1'b1;

    while (pend.size() > 0) begin
      item_t it;
      bit acc;
      it = pend.pop_front();
      for (int g = 0; g < it.gap; g++) begin
        @(negedge clk); #1;
        insn_valid = 1'b0; insn_word = 16'hDEAD;
        bank_sel = ~bank_sel; insn_next_two_word = ~insn_next_two_word; // R10 noise
      end
      acc = 0;
      while (!acc) begin
        @(negedge clk); #1;
        insn_valid = 1'b1; insn_word = it.word;
        insn_next_two_word = it.two; bank_sel = it.bsr;
        acc = insn_ready;
        if (acc) model_accept(it);
      end
      @(negedge clk); #1;
      bank_sel = ~it.bsr; insn_next_two_word = ~it.two; // R10: change after accept
      if (pend.size() == 0 || pend[0].gap > 0) insn_valid = 1'b0;
      else begin
        insn_word = pend[0].word; insn_next_two_word = pend[0].two; bank_sel = pend[0].bsr;
      end
    end
    insn_valid = 1'b0;
    while (expq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule